// File: doc/BRIEF.md
# Tag Reply Lookup and Serializer

This block sits behind a downlink receiver in a card-side contactless front end. Each frame the receiver finishes is offered as a bit count plus the received bits, packed least significant bit first. The block compares the frame with a small fixed query table. The comparison is exact: both the bit count and the full data word must equal a table entry. When a frame matches, the block raises its match flag and arms the reply stored beside that entry. It then waits until the receiver's count of ticks since the reader's last rising edge reaches a fixed start offset. From there it shifts the reply out on one serial pin, least significant bit first and with no line coding. Each bit lasts a fixed number of tick-enable pulses. The serial pin rests low before and after the reply.

Frames enter through a valid/ready handshake. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` is high whenever the block is idle and stays low for the whole of a reply, including the wait before its first bit. The receiver cannot hold a frame, so a frame offered while the block is busy is simply not taken. Such a frame has no effect on the match flag, on the reply in progress or on the serial pin. The edge-interval count and `tick_en` are plain inputs with no handshake.

Top module: `tag_reply_unit`

## Requirements
- R1: After reset `ser_out`, `busy` and `match` are low and `frm_ready` is high.
- R2: A taken frame matches only when `frm_len` is 7 and all 16 bits of `frm_data` equal 0x0055. On a match, `match` and `busy` are high from the cycle after the handshake.
- R3: A taken frame that does not match drives `match` low from the next cycle. `busy` and `ser_out` stay low.
- R4: While `busy` is high, `frm_ready` is low. A frame offered in that time is not taken and changes neither `match` nor the reply on `ser_out`.
- R5: After a match, `ser_out` stays low until the first clock edge at which `edge_ticks` is 490 or more. The first reply bit appears in the cycle after that edge.
- R6: Each reply bit is held for exactly 150 cycles with `tick_en` high, counted from the edge that started it. Cycles with `tick_en` low do not count, and `ser_out` changes only after an edge that has `tick_en` high.
- R7: The reply to the table entry is the 6-bit value 0x3B, sent least significant bit first: 1, 1, 0, 1, 1, 1.
- R8: At the end of the last reply bit, `ser_out` returns low and `busy` falls in the same cycle. `frm_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Receiver offers a finished frame |
| frm_ready | output | 1 | Block can take a frame (idle) |
| frm_data | input | 16 | Received bits, first bit in bit 0, unused bits zero |
| frm_len | input | 5 | Number of received bits |
| edge_ticks | input | CNT_W (12) | Ticks since the reader's last rising edge |
| tick_en | input | 1 | One-cycle timing tick |
| ser_out | output | 1 | Raw serial reply |
| busy | output | 1 | Reply pending or in progress |
| match | output | 1 | Last taken frame matched the table |

## Verification
`match`, `busy` and `frm_ready` settle one cycle after the handshake. The bench samples them at the falling edge that follows the accepting rising edge. `ser_out` changes one cycle after the edge that sees `edge_ticks` reach 490, and again one cycle after every 150th ticked edge after that. The bench drives a tick on every other cycle and tags each sample with the `edge_ticks` value the preceding rising edge saw. It checks the first and the last ticked sample of every bit, the sample just before the start and the sample at the end, so every expected value follows from tick arithmetic with no tolerance window.

// File: rtl/tagr_pkg.sv
package tagr_pkg;

  localparam int FRM_W = 16;
  localparam int LEN_W = 5;
  localparam int N_ENT = 1;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [FRM_W-1:0] bits;
  } frame_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} st_t;

  // Query side of the lookup table
  function automatic frame_t query_at(int idx);
    frame_t f;
    f = '0;
    case (idx)
      0: begin
        f.len  = LEN_W'(7);
        f.bits = FRM_W'(16'h0055);
      end
      default: ;
    endcase
    return f;
  endfunction

  // Reply side of the lookup table
  function automatic frame_t reply_at(int idx);
    frame_t f;
    f = '0;
    case (idx)
      0: begin
        f.len  = LEN_W'(6);
        f.bits = FRM_W'(16'h003B);
      end
      default: ;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/tagr_matcher.sv
module tagr_matcher
  import tagr_pkg::*;
(
  input  frame_t frm_i,
  output logic   hit_o,
  output frame_t reply_o
);

  logic [N_ENT-1:0] hit_v;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign hit_v[g] = (frm_i == query_at(g));
  end

  // lowest index wins if entries overlap
  always_comb begin
    hit_o   = |hit_v;
    reply_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) reply_o = reply_at(i);
    end
  end

endmodule

// File: rtl/tagr_bit_timer.sv
module tagr_bit_timer #(
  parameter int BIT_TICKS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int TW = $clog2(BIT_TICKS + 1);

  logic [TW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == TW'(1));

  // reloaded at every bit boundary so periods never accumulate error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TW'(BIT_TICKS);
    end else if (load_i || done_o) begin
      cnt_q <= TW'(BIT_TICKS);
    end else if (run_i && tick_i) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

endmodule

// File: rtl/tagr_shifter.sv
module tagr_shifter #(
  parameter int DW = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] len_i,
  input  logic          adv_i,
  output logic          bit_o,
  output logic          last_o
);

  logic [DW-1:0] sreg_q;
  logic [LW-1:0] left_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      out_q  <= data_i[0];
      sreg_q <= data_i >> 1;
      left_q <= len_i - LW'(1);
    end else if (adv_i) begin
      if (left_q == '0) begin
        out_q <= 1'b0;
      end else begin
        out_q  <= sreg_q[0];
        sreg_q <= sreg_q >> 1;
        left_q <= left_q - LW'(1);
      end
    end
  end

  assign bit_o  = out_q;
  assign last_o = (left_q == '0);

endmodule

// File: rtl/tag_reply_unit.sv
module tag_reply_unit
  import tagr_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int START_TICKS = 490,
  parameter int BIT_TICKS   = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [FRM_W-1:0] frm_data,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [CNT_W-1:0] edge_ticks,
  input  logic             tick_en,
  output logic             ser_out,
  output logic             busy,
  output logic             match
);

  frame_t frm_in, reply, reply_q;
  logic   hit, accept, start, bit_done, last_bit, match_q;
  st_t    st_q;

  assign frm_in = {frm_len, frm_data};

  tagr_matcher u_match (
    .frm_i   (frm_in),
    .hit_o   (hit),
    .reply_o (reply)
  );

  assign frm_ready = (st_q == ST_IDLE);
  assign accept    = frm_valid && frm_ready;
  assign start     = (st_q == ST_WAIT) && (edge_ticks >= CNT_W'(START_TICKS));

  tagr_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .run_i  (st_q == ST_SEND),
    .tick_i (tick_en),
    .done_o (bit_done)
  );

  tagr_shifter #(.DW(FRM_W), .LW(LEN_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .data_i (reply_q.bits),
    .len_i  (reply_q.len),
    .adv_i  (bit_done),
    .bit_o  (ser_out),
    .last_o (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      reply_q <= '0;
      match_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          match_q <= hit;
          reply_q <= reply;
          if (hit) st_q <= ST_WAIT;
        end
        ST_WAIT: if (start) st_q <= ST_SEND;
        ST_SEND: if (bit_done && last_bit) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign match = match_q;

  // R3: a taken frame that misses leaves everything quiet
  p_nohit_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !hit) |=> (!match && !busy && !ser_out));

  // R4: frames offered during a reply leave the match flag alone
  p_busy_holds_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frm_valid) |=> $stable(match));

  // R5: line stays low while waiting for the start offset
  p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && edge_ticks < CNT_W'(START_TICKS)) |=> (!ser_out && busy));

  // R6: without a tick the current bit is held
  p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && !tick_en) |=> $stable(ser_out));

  // R8: the line is low once the reply has finished
  p_end_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ser_out);

endmodule

// File: tb/tag_reply_unit_tb_top.sv
module tag_reply_unit_tb_top;

  localparam int START = 490;
  localparam int BITT  = 150;
  localparam int NRESP = 6;
  localparam logic [15:0] RESP = 16'h003B;
  localparam int FEND  = 170;   // receiver closes a frame this long after the last edge

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [15:0] frm_data = '0;
  logic [4:0]  frm_len = '0;
  logic [11:0] edge_ticks = '0;
  logic        tick_en = 1'b0;
  logic        ser_out, busy, match;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit phase = 1'b0;
  bit mon_on = 1'b0;
  bit o_ser, o_busy, o_match, o_ready, o_first;
  int o_e;

  always #4 clk = ~clk;

  tag_reply_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .frm_data   (frm_data),
    .frm_len    (frm_len),
    .edge_ticks (edge_ticks),
    .tick_en    (tick_en),
    .ser_out    (ser_out),
    .busy       (busy),
    .match      (match)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: sample outputs of the last rising edge, then drive the next one
  task automatic cyc(input bit do_edge);
    @(negedge clk);
    o_ser = ser_out; o_busy = busy; o_match = match; o_ready = frm_ready;
    o_e = int'(edge_ticks); o_first = tick_en;
    if (mon_on && o_first) begin
      if (o_e == START - 1)
        check(!o_ser && o_busy, "R5", "line before start offset", int'(o_ser), 0);
      for (int k = 0; k < NRESP; k++) begin
        if (o_e == START + BITT * k)
          check(o_ser == RESP[k], "R7", $sformatf("first tick of bit %0d", k),
                int'(o_ser), int'(RESP[k]));
        if (o_e == START + BITT * k + BITT - 1)
          check(o_ser == RESP[k], "R6", $sformatf("last tick of bit %0d", k),
                int'(o_ser), int'(RESP[k]));
      end
      if (o_e == START + BITT * NRESP)
        check(!o_ser && !o_busy && o_ready, "R8", "line and busy after last bit",
              int'({o_ser, o_busy}), 0);
    end
    frm_valid = 1'b0;
    phase = ~phase;
    tick_en = phase;
    if (phase) edge_ticks = do_edge ? 12'd0 : ((edge_ticks == 12'hFFF) ? edge_ticks : edge_ticks + 12'd1);
  endtask

  task automatic tick1(input bit do_edge);
    do begin
      cyc(do_edge);
    end while (!tick_en);
  endtask

  // reader sends bits as edge intervals; the receiver model closes the frame
  task automatic reader_frame(input logic [15:0] bits, input int n);
    tick1(1'b1);
    for (int i = 0; i < n; i++) begin
      int iv;
      iv = bits[i] ? 150 : 90;
      repeat (iv - 1) tick1(1'b0);
      tick1(1'b1);
    end
    while (int'(edge_ticks) < FEND) tick1(1'b0);
    frm_valid = 1'b1;
    frm_data  = bits & 16'((32'h1 << n) - 1);
    frm_len   = 5'(n);
  endtask

  task automatic good_run(input bit inject);
    bit injected;
    injected = 1'b0;
    reader_frame(16'h0055, 7);
    mon_on = 1'b1;
    cyc(1'b0);
    check(o_match && o_busy && !o_ready, "R2", "match/busy after query",
          int'({o_match, o_busy, o_ready}), 6);
    while (int'(edge_ticks) < START + BITT * NRESP + 4) begin
      tick1(1'b0);
      if (inject && !injected && int'(edge_ticks) == 700) begin
        injected = 1'b1;
        frm_valid = 1'b1; frm_data = 16'h0000; frm_len = 5'd3;
        cyc(1'b0);
        check(o_match && o_busy && !o_ready, "R4", "frame offered while busy",
              int'({o_match, o_busy, o_ready}), 6);
      end
    end
    mon_on = 1'b0;
  endtask

  task automatic miss_run(input logic [15:0] bits, input int n);
    int bad;
    bad = 0;
    reader_frame(bits, n);
    cyc(1'b0);
    check(!o_match && !o_busy && o_ready, "R3", $sformatf("miss %0d bits 0x%0h", n, bits),
          int'({o_match, o_busy, o_ready}), 1);
    while (int'(edge_ticks) < START + BITT * NRESP + 4) begin
      tick1(1'b0);
      if (o_ser || o_busy) bad++;
    end
    check(bad == 0, "R3", "line quiet after miss", bad, 0);
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0);
    check(!o_ser && !o_busy && !o_match && o_ready, "R1", "reset state",
          int'({o_ser, o_busy, o_match, o_ready}), 1);

    good_run(1'b0);
    miss_run(16'h0054, 7);          // value differs by one bit
    good_run(1'b1);
    miss_run(16'h0015, 6);          // short frame
    miss_run(16'h00D5, 8);          // long frame sharing the low bits

    // sweep every 7-bit value except the query
    bad = 0;
    for (int d = 0; d < 128; d++) begin
      if (d != 16'h55) begin
        frm_valid = 1'b1; frm_data = 16'(d); frm_len = 5'd7;
        cyc(1'b0);
        if (o_match || o_busy) bad++;
      end
    end
    check(bad == 0, "R2", "7-bit value sweep", bad, 0);

    // sweep every length with the query value
    bad = 0;
    for (int l = 0; l < 32; l++) begin
      if (l != 7) begin
        frm_valid = 1'b1; frm_data = 16'h0055; frm_len = 5'(l);
        cyc(1'b0);
        if (o_match || o_busy) bad++;
      end
    end
    check(bad == 0, "R2", "length sweep", bad, 0);

    // a stray high bit beyond the count must not match
    frm_valid = 1'b1; frm_data = 16'h0155; frm_len = 5'd7;
    cyc(1'b0);
    check(!o_match && !o_busy, "R2", "upper data bit set", int'({o_match, o_busy}), 0);

    good_run(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule